// File: doc/BRIEF.md
# Time-Stamped Hit Word Packer

This block turns hit events from a group of discriminator lanes into a stream of 32-bit time data words. It keeps its own time base. An 11-bit coarse counter steps once per system clock and wraps every 2048 cycles, which is 10.24 us at a 5 ns clock. An epoch counter counts those wraps. Each hit is stamped with the coarse and epoch values of the cycle in which it is sampled. It is packed together with its lane number, a ready-made fine-time value, the edge polarity and an "approximate value" flag.

Hits that arrive in the same cycle are each held in a per-lane slot. They move into a small queue one per cycle, lowest lane first. The queue drains onto a valid/ready output. Each word carries only the coarse part of the time, so the packer places an epoch word in the stream ahead of any time word whose epoch differs from the last one announced. Epoch words also come first after reset. A receiver can therefore rebuild the full time of hits that lie far apart.

Top module: `tdc_hit_packer`

## Requirements
- R1: A time data word has bit 31 = 1, bit 30 = 0, bit 29 = the lane's approx flag, bits 28:22 = the lane index as the channel number, bits 21:12 = the 10-bit fine value, bit 11 = 1 for a rising edge and 0 for a falling one, and bits 10:0 = the coarse stamp.
- R2: The coarse counter is 0 after reset and advances by one on every clock. A hit is stamped with the value the counter holds just before the edge that samples the strobe.
- R3: The epoch counter is 0 after reset and advances by one exactly when the coarse counter goes from 2047 to 0.
- R4: An epoch word has bits 31:29 = 3'b011, bit 28 = 0, and bits 27:0 = the epoch value.
- R5: The first time word after reset is preceded by an epoch word. Every later time word whose epoch differs from the last epoch word sent is also preceded by one, carrying that hit's epoch.
- R6: Hits sampled in the same cycle leave the block in ascending lane order.
- R7: While out_vld is high and out_rdy is low, out_vld stays high and out_word stays unchanged. No queued or held hit is lost during the stall.
- R8: Every sampled hit produces exactly one time word, provided a lane does not strobe again while its previous hit is still held.
- R9: After reset and with no hits, out_vld stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one coarse tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_stb | input | N_CH | One-cycle hit strobe per lane |
| hit_fine | input | N_CH*10 | Fine-time values, lane i at bits [10*i+9:10*i] |
| hit_rising | input | N_CH | Edge polarity per lane, 1 = rising |
| hit_approx | input | N_CH | Approximate-value flag per lane |
| out_vld | output | 1 | Output word valid |
| out_rdy | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Time data word or epoch word |

## Verification
If the coarse or epoch state were wrong, the error would show up in the low eleven bits, or in the epoch payload, of the very next word after a hit. A wrong epoch would also show up as a missing or extra epoch word at the next 2048-cycle wrap. If the record kept for the last announced epoch were wrong, the stream would break within one word of a hit: an epoch word would be repeated, or a time word would arrive without one. Errors in the lane slots or the queue would show up as words out of lane order, duplicated or missing. During a stall they would show up as a changed word. These are caught when the stream is compared against an independent model at every accepted word and again when the block drains.

// File: rtl/tdc_fmt_pkg.sv
package tdc_fmt_pkg;
  localparam int CH_W     = 7;
  localparam int FINE_W   = 10;
  localparam int COARSE_W = 11;
  localparam int EPOCH_W  = 28;
  localparam int WORD_W   = 32;

  typedef struct packed {
    logic                approx;
    logic [CH_W-1:0]     chan;
    logic [FINE_W-1:0]   fine;
    logic                rising;
    logic [COARSE_W-1:0] coarse;
    logic [EPOCH_W-1:0]  epoch;
  } hit_rec_t;

  // Time data word: marker, reserved, approx, channel, fine, edge, coarse.
  function automatic logic [WORD_W-1:0] time_word(input hit_rec_t r);
    return {1'b1, 1'b0, r.approx, r.chan, r.fine, r.rising, r.coarse};
  endfunction

  // Epoch word: 3'b011 header, one reserved zero, epoch payload.
  function automatic logic [WORD_W-1:0] epoch_word(input logic [EPOCH_W-1:0] e);
    return {3'b011, 1'b0, e};
  endfunction
endpackage

// File: rtl/tdc_timebase.sv
module tdc_timebase
  import tdc_fmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  output logic [COARSE_W-1:0] coarse,
  output logic [EPOCH_W-1:0]  epoch
);
  logic wrap;
  assign wrap = (coarse == {COARSE_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse <= '0;
      epoch  <= '0;
    end else begin
      coarse <= coarse + 1'b1;
      if (wrap) epoch <= epoch + 1'b1;
    end
  end

  a_r2_coarse_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> coarse == COARSE_W'($past(coarse) + 1'b1));
  a_r3_epoch_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coarse) == {COARSE_W{1'b1}} && $past(rst_n) |-> epoch == EPOCH_W'($past(epoch) + 1'b1));
  a_r3_epoch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(coarse) != {COARSE_W{1'b1}} && $past(rst_n) |-> $stable(epoch));
endmodule

// File: rtl/tdc_hit_arbiter.sv
module tdc_hit_arbiter
  import tdc_fmt_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        hit_stb,
  input  logic [N_CH*FINE_W-1:0] hit_fine,
  input  logic [N_CH-1:0]        hit_rising,
  input  logic [N_CH-1:0]        hit_approx,
  input  logic [COARSE_W-1:0]    coarse,
  input  logic [EPOCH_W-1:0]     epoch,
  input  logic                   q_full,
  output logic                   push,
  output hit_rec_t               push_rec
);
  logic [N_CH-1:0] pend;
  logic [N_CH-1:0] take;
  logic [N_CH-1:0] grant;
  hit_rec_t        slot [N_CH];

  // Lowest pending lane wins when the queue has room.
  assign take  = q_full ? '0 : pend;
  assign grant = take & (~take + 1'b1);
  assign push  = |grant;

  always_comb begin
    push_rec = '0;
    for (int i = 0; i < N_CH; i++)
      if (grant[i]) push_rec = slot[i];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
      end else if (hit_stb[g]) begin
        pend[g] <= 1'b1;
        slot[g] <= '{approx: hit_approx[g], chan: CH_W'(g),
                     fine: hit_fine[g*FINE_W +: FINE_W], rising: hit_rising[g],
                     coarse: coarse, epoch: epoch};
      end else if (grant[g]) begin
        pend[g] <= 1'b0;
      end
    end

    a_r7_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
      pend[g] && !grant[g] |=> pend[g]);
  end

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/tdc_hit_fifo.sv
module tdc_hit_fifo
  import tdc_fmt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  hit_rec_t push_rec,
  input  logic     pop,
  output hit_rec_t head,
  output logic     empty,
  output logic     full
);
  localparam int AW = $clog2(DEPTH);

  hit_rec_t    mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);
  assign head  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr[AW-1:0]] <= push_rec;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tdc_hit_packer.sv
module tdc_hit_packer
  import tdc_fmt_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int Q_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        hit_stb,
  input  logic [N_CH*FINE_W-1:0] hit_fine,
  input  logic [N_CH-1:0]        hit_rising,
  input  logic [N_CH-1:0]        hit_approx,
  output logic                   out_vld,
  input  logic                   out_rdy,
  output logic [WORD_W-1:0]      out_word
);
  logic [COARSE_W-1:0] coarse;
  logic [EPOCH_W-1:0]  epoch;
  logic                push, pop, q_empty, q_full;
  hit_rec_t            push_rec, head;

  logic                ep_known;
  logic [EPOCH_W-1:0]  ep_last;
  logic                need_ep, fire_ep, fire_time;

  tdc_timebase u_tb (.clk(clk), .rst_n(rst_n), .coarse(coarse), .epoch(epoch));

  tdc_hit_arbiter #(.N_CH(N_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .hit_fine(hit_fine),
    .hit_rising(hit_rising), .hit_approx(hit_approx), .coarse(coarse),
    .epoch(epoch), .q_full(q_full), .push(push), .push_rec(push_rec));

  tdc_hit_fifo #(.DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .push_rec(push_rec), .pop(pop),
    .head(head), .empty(q_empty), .full(q_full));

  // An epoch word goes out first whenever the head's epoch is unannounced.
  assign need_ep   = !q_empty && (!ep_known || head.epoch != ep_last);
  assign out_vld   = !q_empty;
  assign out_word  = need_ep ? epoch_word(head.epoch) : time_word(head);
  assign fire_ep   = out_vld && out_rdy && need_ep;
  assign fire_time = out_vld && out_rdy && !need_ep;
  assign pop       = fire_time;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_known <= 1'b0;
      ep_last  <= '0;
    end else if (fire_ep) begin
      ep_known <= 1'b1;
      ep_last  <= head.epoch;
    end
  end

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_word));
  a_r5_time_follows_epoch: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ep |=> out_vld && out_word[WORD_W-1]);
  a_r9_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_vld);
endmodule

// File: tb/tdc_hit_packer_tb.sv
`timescale 1ns/1ps
module tdc_hit_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 4;
  localparam int FW = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   hit_stb = '0;
  logic [N_CH*FW-1:0] hit_fine = '0;
  logic [N_CH-1:0]   hit_rising = '0;
  logic [N_CH-1:0]   hit_approx = '0;
  logic              out_vld;
  logic              out_rdy = 1'b1;
  logic [31:0]       out_word;

  tdc_hit_packer #(.N_CH(N_CH), .Q_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_stb(hit_stb), .hit_fine(hit_fine),
    .hit_rising(hit_rising), .hit_approx(hit_approx), .out_vld(out_vld),
    .out_rdy(out_rdy), .out_word(out_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int tick = 0, ep = 0, last_ep = -1;
  int hits_issued = 0, time_seen = 0;
  logic [31:0] exp_q[$];
  bit prev_stall = 0;
  logic [31:0] prev_word = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Reference model: its own time base, stream built in arrival order.
  always @(posedge clk) begin
    if (!rst_n) begin
      tick = 0; ep = 0; last_ep = -1;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (hit_stb[i]) begin
          if (ep != last_ep) begin  // R5
            exp_q.push_back(32'h6000_0000 + 32'(ep));  // R4
            last_ep = ep;
          end
          exp_q.push_back(32'h8000_0000 + (32'(hit_approx[i]) << 29) + (32'(i) << 22)
                          + (32'(hit_fine[i*FW +: FW]) << 12) + (32'(hit_rising[i]) << 11)
                          + 32'(tick));  // R1 R2
          hits_issued++;
        end
      end
      tick++;
      if (tick == 2048) begin tick = 0; ep++; end  // R3
    end
  end

  // Compare after the inputs settle, before the next edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(out_vld && out_word == prev_word, "R7 stall hold", out_word, prev_word);
      if (out_vld && out_rdy) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected word", out_word, 32'h0);
        else begin
          logic [31:0] w;
          w = exp_q.pop_front();
          if (w[31]) chk(out_word == w, "R1 R2 R6 time word", out_word, w);
          else       chk(out_word == w, "R3 R4 R5 epoch word", out_word, w);
          if (out_word[31]) time_seen++;
        end
      end
      prev_stall = out_vld && !out_rdy;
      prev_word  = out_word;
    end
  end

  task automatic fire(input logic [N_CH-1:0] lanes);
    @(negedge clk);
    hit_stb = lanes;
    for (int i = 0; i < N_CH; i++) begin
      hit_fine[i*FW +: FW] = FW'($urandom);
      hit_rising[i] = $urandom % 2;
      hit_approx[i] = $urandom % 2;
    end
    @(negedge clk);
    hit_stb = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9: idle after reset
    repeat (3) begin
      @(negedge clk); #2;
      chk(!out_vld, "R9 idle after reset", 32'(out_vld), 32'h0);
    end
    // Single hit: epoch word first (R5), then R1 layout
    fire(4'b0100);
    repeat (6) @(negedge clk);
    // Simultaneous hits on all lanes (R6)
    fire(4'b1111);
    repeat (8) @(negedge clk);
    fire(4'b1010);
    repeat (8) @(negedge clk);
    // Back-pressure: 12 hits against an 8-deep queue (R7 R8)
    out_rdy = 1'b0;
    fire(4'b1111);
    repeat (5) @(negedge clk);
    fire(4'b1111);
    repeat (5) @(negedge clk);
    fire(4'b1111);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      out_rdy = $urandom % 2;
    end
    out_rdy = 1'b1;
    // Coarse wrap 2047 -> 0 with an epoch change between two hits (R2 R3 R5)
    while (tick != 2047) @(negedge clk);
    hit_stb = 4'b0010; hit_fine[1*FW +: FW] = 10'h3FF; hit_rising[1] = 1'b1; hit_approx[1] = 1'b0;
    @(negedge clk);
    hit_stb = 4'b0100; hit_fine[2*FW +: FW] = 10'h001; hit_rising[2] = 1'b0; hit_approx[2] = 1'b1;
    @(negedge clk);
    hit_stb = '0;
    // Random traffic with random back-pressure across another wrap
    for (int b = 0; b < 150; b++) begin
      fire(4'($urandom));
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        out_rdy = ($urandom % 4) != 0;
      end
    end
    out_rdy = 1'b1;
    for (int k = 0; k < 200 && (exp_q.size() != 0 || out_vld); k++) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'h0);
    chk(time_seen == hits_issued, "R8 one word per hit", 32'(time_seen), 32'(hits_issued));
    chk(!out_vld, "R9 idle when drained", 32'(out_vld), 32'h0);
    finish_run();
  end
endmodule